// File: doc/BRIEF.md
# USB Host Controller Control Register

This block is the control word of a USB host controller, reached over a plain register bus with a write strobe, write data and a registered read-back. It holds five software fields: remote-wakeup enable, remote-wakeup connected, interrupt routing, the two-bit functional state and the bulk-list enable. It also keeps the hardware that goes with those fields. A hardware reset and a software reset clear different sets of fields. A delay counter decides when start-of-frame generation may begin after the controller enters the operational state. One state change can be made without software: suspend to resume, when a downstream port reports resume signalling.

The block drives several outputs. It presents the functional state and steers the controller's interrupt events to either the normal host interrupt or the system-management interrupt. It raises a remote-wakeup request. It reports whether frames have started, with a one-cycle pulse on the first frame. At each frame boundary, supplied by an external frame counter, it passes on a per-frame bulk-processing enable. After a hardware reset it asks the root ports to drive reset signalling until software leaves the reset state.

Top module: `usb_hc_ctrl_reg`

## Requirements
- R1: A hardware reset (`rst` high at a clock edge) sets the state to 00 and clears all five fields, `rd_data`, `sof_active` and `bulk_run`. It sets `port_reset_req`, which stays high until the state leaves 00.
- R2: A software reset (`sw_reset` high at an edge, taking priority over a write) sets the state to 11 (suspend) and clears the wakeup-enable and bulk-enable fields.
- R3: The wakeup-connected field (bit 9) and the routing field (bit 8) keep their values across a software reset. Only a hardware reset or a write changes them.
- R4: A write loads the fields from these positions: bit 10 wakeup enable, bit 9 wakeup connected, bit 8 routing, bits 7:6 state (00 reset, 01 resume, 10 operational, 11 suspend) and bit 5 bulk enable. `hc_state` follows at the write edge. `rd_data` shows the same layout one edge later.
- R5: Bits 31:11 and 4:0 of `rd_data` always read zero. Data written to them has no effect.
- R6: With no write and no software reset, the state changes on its own only from 11 to 01, at an edge where `resume_detect` is high. A write in the same cycle takes priority over this change.
- R7: After a write moves the state into 10 from another state, `sof_active` rises on the (DELAY_CYC+1)-th edge counted from the write edge, where DELAY_CYC = CLK_KHZ × START_DELAY_MS. `sof_first` pulses for exactly that one cycle. Writing 10 again while already in 10 does not restart the count.
- R8: Leaving state 10 clears `sof_active` at the next edge and cancels any count in progress, so frames do not start until the state is entered again.
- R9: `wakeup_req` is the wakeup-enable field AND `resume_status`, registered one edge. The wakeup-enable field has no effect on `host_irq` or `smi_irq`.
- R10: An `irq_event` appears one edge later on `host_irq` when the routing field is 0, and on `smi_irq` when it is 1, never on both.
- R11: `bulk_run` takes the bulk-enable field only at an edge where `sof_pulse` is high while `sof_active` is high, and holds its value between such edges. It is 0 while `sof_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| sw_reset | input | 1 | Software reset pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Registered read-back of the control word |
| resume_detect | input | 1 | Resume signalling seen on a downstream port |
| resume_status | input | 1 | Resume-detected interrupt status bit |
| irq_event | input | 1 | Controller interrupt event to be routed |
| sof_pulse | input | 1 | Frame boundary pulse from the frame counter |
| hc_state | output | 2 | Functional state |
| smi_route | output | 1 | Interrupt routing select (1 = system management) |
| host_irq | output | 1 | Interrupt to the normal host interrupt |
| smi_irq | output | 1 | Interrupt to the system-management interrupt |
| wakeup_req | output | 1 | Remote-wakeup request to the host system |
| sof_active | output | 1 | Start-of-frame generation has begun |
| sof_first | output | 1 | One-cycle pulse when the first frame begins |
| bulk_run | output | 1 | Bulk-list processing enabled for the current frame |
| port_reset_req | output | 1 | Request for reset signalling toward downstream ports |

## Verification
The assertions assume that `sof_pulse` comes from a frame counter and has meaning only while frames run. They also assume that `resume_detect` and `sw_reset` are single-cycle events rather than levels held across writes. The timing assertion assumes that the operational state is entered only through a bus write, never through a reset. The stimulus drives every event for one cycle. It never raises `wr_en` and `sw_reset` together. It applies routed events and resume status only in idle cycles after each operation, so every expected output follows from fields that are already settled.

// File: rtl/usb_hcr_pkg.sv
package usb_hcr_pkg;

  localparam int unsigned REG_W        = 32;
  localparam int unsigned BIT_BULK     = 5;
  localparam int unsigned BIT_STATE_LO = 6;
  localparam int unsigned BIT_ROUTE    = 8;
  localparam int unsigned BIT_WCONN    = 9;
  localparam int unsigned BIT_WEN      = 10;

  typedef enum logic [1:0] {
    HC_RESET   = 2'b00,
    HC_RESUME  = 2'b01,
    HC_OPER    = 2'b10,
    HC_SUSPEND = 2'b11
  } hc_state_e;

  typedef struct packed {
    logic      wake_en;
    logic      wake_conn;
    logic      irq_route;
    hc_state_e state;
    logic      bulk_en;
  } ctrl_fields_t;

  localparam ctrl_fields_t FIELDS_HW_RST = '{
    wake_en:   1'b0,
    wake_conn: 1'b0,
    irq_route: 1'b0,
    state:     HC_RESET,
    bulk_en:   1'b0
  };

  // Places the held fields at their software-visible bit positions.
  function automatic logic [REG_W-1:0] fields_to_word(ctrl_fields_t f);
    logic [REG_W-1:0] w;
    w                      = '0;
    w[BIT_WEN]             = f.wake_en;
    w[BIT_WCONN]           = f.wake_conn;
    w[BIT_ROUTE]           = f.irq_route;
    w[BIT_STATE_LO +: 2]   = f.state;
    w[BIT_BULK]            = f.bulk_en;
    return w;
  endfunction

endpackage

// File: rtl/hcr_ctrl_fields.sv
module hcr_ctrl_fields
  import usb_hcr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_reset,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               resume_detect,
  output ctrl_fields_t       fields_q,
  output logic               port_reset_q,
  output logic [REG_W-1:0]   rd_data
);

  ctrl_fields_t fields_d;
  logic         unused_wr_bits;

  // Reserved positions are never stored.
  assign unused_wr_bits = ^{wr_data[REG_W-1:BIT_WEN+1], wr_data[BIT_BULK-1:0]};

  always_comb begin
    fields_d = fields_q;
    if (sw_reset) begin
      fields_d.state   = HC_SUSPEND;
      fields_d.wake_en = 1'b0;
      fields_d.bulk_en = 1'b0;
    end else if (wr_en) begin
      fields_d.wake_en   = wr_data[BIT_WEN];
      fields_d.wake_conn = wr_data[BIT_WCONN];
      fields_d.irq_route = wr_data[BIT_ROUTE];
      fields_d.state     = hc_state_e'(wr_data[BIT_STATE_LO +: 2]);
      fields_d.bulk_en   = wr_data[BIT_BULK];
    end else if (fields_q.state == HC_SUSPEND && resume_detect) begin
      fields_d.state = HC_RESUME;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fields_q     <= FIELDS_HW_RST;
      port_reset_q <= 1'b1;
      rd_data      <= '0;
    end else begin
      fields_q <= fields_d;
      if (fields_d.state != HC_RESET) begin
        port_reset_q <= 1'b0;
      end
      rd_data <= fields_to_word(fields_q);
    end
  end

endmodule

// File: rtl/hcr_sof_timer.sv
module hcr_sof_timer #(
  parameter int unsigned DELAY_CYC = 200000
) (
  input  logic clk,
  input  logic rst,
  input  logic in_oper,
  output logic sof_active,
  output logic sof_first
);

  localparam int unsigned CW = (DELAY_CYC < 2) ? 1 : $clog2(DELAY_CYC);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

  logic          was_oper;
  logic          armed;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      was_oper   <= 1'b0;
      armed      <= 1'b0;
      cnt        <= '0;
      sof_active <= 1'b0;
      sof_first  <= 1'b0;
    end else begin
      was_oper  <= in_oper;
      sof_first <= 1'b0;
      if (!in_oper) begin
        armed      <= 1'b0;
        cnt        <= '0;
        sof_active <= 1'b0;
      end else if (!was_oper) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed) begin
        if (cnt == LAST) begin
          armed      <= 1'b0;
          sof_active <= 1'b1;
          sof_first  <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/hcr_event_route.sv
module hcr_event_route (
  input  logic clk,
  input  logic rst,
  input  logic irq_event,
  input  logic irq_route,
  input  logic wake_en,
  input  logic resume_status,
  input  logic sof_pulse,
  input  logic sof_active,
  input  logic bulk_en,
  output logic host_irq,
  output logic smi_irq,
  output logic wakeup_req,
  output logic bulk_run
);

  always_ff @(posedge clk) begin
    if (rst) begin
      host_irq   <= 1'b0;
      smi_irq    <= 1'b0;
      wakeup_req <= 1'b0;
      bulk_run   <= 1'b0;
    end else begin
      host_irq   <= irq_event & ~irq_route;
      smi_irq    <= irq_event &  irq_route;
      wakeup_req <= wake_en & resume_status;
      if (!sof_active) begin
        bulk_run <= 1'b0;
      end else if (sof_pulse) begin
        bulk_run <= bulk_en;
      end
    end
  end

endmodule

// File: rtl/usb_hc_ctrl_reg.sv
module usb_hc_ctrl_reg
  import usb_hcr_pkg::*;
#(
  parameter int unsigned CLK_KHZ        = 200000,
  parameter int unsigned START_DELAY_MS = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sw_reset,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        resume_detect,
  input  logic        resume_status,
  input  logic        irq_event,
  input  logic        sof_pulse,
  output logic [1:0]  hc_state,
  output logic        smi_route,
  output logic        host_irq,
  output logic        smi_irq,
  output logic        wakeup_req,
  output logic        sof_active,
  output logic        sof_first,
  output logic        bulk_run,
  output logic        port_reset_req
);

  localparam int unsigned DELAY_CYC = CLK_KHZ * START_DELAY_MS;

  ctrl_fields_t fields_q;

  hcr_ctrl_fields u_fields (
    .clk           (clk),
    .rst           (rst),
    .sw_reset      (sw_reset),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .resume_detect (resume_detect),
    .fields_q      (fields_q),
    .port_reset_q  (port_reset_req),
    .rd_data       (rd_data)
  );

  hcr_sof_timer #(
    .DELAY_CYC (DELAY_CYC)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .in_oper    (fields_q.state == HC_OPER),
    .sof_active (sof_active),
    .sof_first  (sof_first)
  );

  hcr_event_route u_route (
    .clk           (clk),
    .rst           (rst),
    .irq_event     (irq_event),
    .irq_route     (fields_q.irq_route),
    .wake_en       (fields_q.wake_en),
    .resume_status (resume_status),
    .sof_pulse     (sof_pulse),
    .sof_active    (sof_active),
    .bulk_en       (fields_q.bulk_en),
    .host_irq      (host_irq),
    .smi_irq       (smi_irq),
    .wakeup_req    (wakeup_req),
    .bulk_run      (bulk_run)
  );

  assign hc_state  = fields_q.state;
  assign smi_route = fields_q.irq_route;

endmodule

// File: rtl/hcr_checker.sv
module hcr_checker #(
  parameter int unsigned DELAY_CYC = 200000
) (
  input logic        clk,
  input logic        rst,
  input logic        sw_reset,
  input logic        wr_en,
  input logic        resume_detect,
  input logic        resume_status,
  input logic        irq_event,
  input logic        sof_pulse,
  input logic [31:0] rd_data,
  input logic [1:0]  hc_state,
  input logic        smi_route,
  input logic        host_irq,
  input logic        smi_irq,
  input logic        wakeup_req,
  input logic        sof_active,
  input logic        sof_first,
  input logic        bulk_run,
  input logic        port_reset_req,
  input logic        wake_en
);

  logic [31:0] oper_cnt;

  always_ff @(posedge clk) begin
    if (rst || hc_state != 2'b10) begin
      oper_cnt <= '0;
    end else if (oper_cnt != '1) begin
      oper_cnt <= oper_cnt + 32'd1;
    end
  end

  p_hw_reset_r1: assert property (@(posedge clk)
    rst |=> (hc_state == 2'b00 && port_reset_req && !sof_active && !bulk_run));

  p_sw_reset_r2: assert property (@(posedge clk) disable iff (rst)
    sw_reset |=> hc_state == 2'b11);

  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    sw_reset |=> smi_route == $past(smi_route));

  p_reserved_r5: assert property (@(posedge clk) disable iff (rst)
    rd_data[31:11] == '0 && rd_data[4:0] == '0);

  p_self_resume_r6: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !sw_reset && hc_state == 2'b11 && resume_detect) |=> hc_state == 2'b01);

  p_no_self_change_r6: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !sw_reset && hc_state != 2'b11) |=> $stable(hc_state));

  p_sof_delay_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sof_active) |-> oper_cnt == 32'(DELAY_CYC + 1));

  p_sof_first_r7: assert property (@(posedge clk) disable iff (rst)
    sof_first |-> sof_active);

  p_cancel_r8: assert property (@(posedge clk) disable iff (rst)
    hc_state != 2'b10 |=> !sof_active);

  p_wakeup_r9: assert property (@(posedge clk) disable iff (rst)
    (wake_en && resume_status) |=> wakeup_req);

  p_no_wakeup_r9: assert property (@(posedge clk) disable iff (rst)
    !resume_status |=> !wakeup_req);

  p_host_route_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_event && !smi_route) |=> (host_irq && !smi_irq));

  p_smi_route_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_event && smi_route) |=> (smi_irq && !host_irq));

  p_bulk_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (sof_active && !sof_pulse) |=> $stable(bulk_run));

  p_bulk_off_r11: assert property (@(posedge clk) disable iff (rst)
    !sof_active |=> !bulk_run);

endmodule

bind usb_hc_ctrl_reg hcr_checker #(.DELAY_CYC(DELAY_CYC)) u_hcr_checker (
  .clk            (clk),
  .rst            (rst),
  .sw_reset       (sw_reset),
  .wr_en          (wr_en),
  .resume_detect  (resume_detect),
  .resume_status  (resume_status),
  .irq_event      (irq_event),
  .sof_pulse      (sof_pulse),
  .rd_data        (rd_data),
  .hc_state       (hc_state),
  .smi_route      (smi_route),
  .host_irq       (host_irq),
  .smi_irq        (smi_irq),
  .wakeup_req     (wakeup_req),
  .sof_active     (sof_active),
  .sof_first      (sof_first),
  .bulk_run       (bulk_run),
  .port_reset_req (port_reset_req),
  .wake_en        (fields_q.wake_en)
);

// File: tb/usb_hc_ctrl_reg_bench.sv
`timescale 1ns/1ps
module usb_hc_ctrl_reg_bench;

  localparam int unsigned CLK_KHZ = 20;
  localparam int unsigned DLY     = CLK_KHZ;

  logic        clk = 1'b0;
  logic        rst, sw_reset, wr_en, resume_detect, resume_status, irq_event, sof_pulse;
  logic [31:0] wr_data, rd_data;
  logic [1:0]  hc_state;
  logic        smi_route, host_irq, smi_irq, wakeup_req, sof_active, sof_first, bulk_run;
  logic        port_reset_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic       m_wen, m_wconn, m_route, m_bulk;
  logic [1:0] m_state;

  always #2.5 clk = ~clk;

  usb_hc_ctrl_reg #(.CLK_KHZ(CLK_KHZ), .START_DELAY_MS(1)) u_usb_hc_ctrl_reg (
    .clk(clk), .rst(rst), .sw_reset(sw_reset), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .resume_detect(resume_detect), .resume_status(resume_status),
    .irq_event(irq_event), .sof_pulse(sof_pulse), .hc_state(hc_state),
    .smi_route(smi_route), .host_irq(host_irq), .smi_irq(smi_irq),
    .wakeup_req(wakeup_req), .sof_active(sof_active), .sof_first(sof_first),
    .bulk_run(bulk_run), .port_reset_req(port_reset_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    return {21'b0, m_wen, m_wconn, m_route, m_state, m_bulk, 5'b0};
  endfunction

  function automatic void model_write(input logic [31:0] d);
    m_wen   = d[10];
    m_wconn = d[9];
    m_route = d[8];
    m_state = d[7:6];
    m_bulk  = d[5];
  endfunction

  task automatic hw_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_wen = 0; m_wconn = 0; m_route = 0; m_state = 2'b00; m_bulk = 0;
  endtask

  task automatic write_reg(input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1562));
    rst = 1'b1; sw_reset = 0; wr_en = 0; wr_data = '0; resume_detect = 0;
    resume_status = 0; irq_event = 0; sof_pulse = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    m_wen = 0; m_wconn = 0; m_route = 0; m_state = 2'b00; m_bulk = 0;

    // R1: reset state
    check("R1 state", 32'(hc_state), 32'h0);
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 port_reset_req", 32'(port_reset_req), 32'h1);
    check("R1 sof_active", 32'(sof_active), 32'h0);
    idle(3);
    check("R1 port_reset_req held", 32'(port_reset_req), 32'h1);
    write_reg(32'h0000_0040);
    check("R1 port_reset_req cleared", 32'(port_reset_req), 32'h0);
    idle(1);
    check("R4 readback resume", rd_data, 32'h0000_0040);

    // Random operations, R2 R3 R4 R5 R6 R9 R10
    for (int i = 0; i < 600; i++) begin
      int unsigned op;
      logic [31:0] d;
      logic ev, rs;
      op = $urandom % 5;
      d  = $urandom;
      ev = 1'($urandom % 2);
      rs = 1'($urandom % 2);
      @(negedge clk);
      case (op)
        0: begin wr_en = 1; wr_data = d; end
        1: sw_reset = 1;
        2: resume_detect = 1;
        4: begin wr_en = 1; wr_data = d; resume_detect = 1; end
        default: ;
      endcase
      @(negedge clk);
      wr_en = 0; sw_reset = 0; resume_detect = 0;
      irq_event = ev; resume_status = rs;
      case (op)
        0, 4: model_write(d);
        1: begin m_state = 2'b11; m_wen = 0; m_bulk = 0; end
        2: if (m_state == 2'b11) m_state = 2'b01;
        default: ;
      endcase
      @(negedge clk);
      irq_event = 0; resume_status = 0;
      check("R6 R2 state", 32'(hc_state), 32'(m_state));
      check("R4 R5 R3 rd_data", rd_data, exp_word());
      check("R10 host_irq", 32'(host_irq), 32'(ev & ~m_route));
      check("R10 smi_irq", 32'(smi_irq), 32'(ev & m_route));
      check("R9 wakeup_req", 32'(wakeup_req), 32'(m_wen & rs));
    end

    // R3: sticky fields across software reset, cleared by hardware reset
    write_reg(32'hFFFF_F3FF & 32'h0000_0300 | 32'h0000_0080);
    @(negedge clk); sw_reset = 1;
    @(negedge clk); sw_reset = 0;
    idle(1);
    check("R3 kept over sw reset", rd_data, 32'h0000_03C0);
    check("R3 route output", 32'(smi_route), 32'h1);
    hw_reset();
    check("R3 cleared by hw reset", 32'(smi_route), 32'h0);
    idle(1);
    check("R3 readback after hw reset", rd_data, 32'h0);

    // R6: write wins over resume; resume ignored outside suspend
    @(negedge clk); resume_detect = 1;
    @(negedge clk); resume_detect = 0;
    check("R6 no resume from reset", 32'(hc_state), 32'h0);
    write_reg(32'h0000_00C0);
    @(negedge clk); wr_en = 1; wr_data = 32'h0000_0000; resume_detect = 1;
    @(negedge clk); wr_en = 0; resume_detect = 0;
    check("R6 write beats resume", 32'(hc_state), 32'h0);

    // R7: delay to first frame
    write_reg(32'h0000_00A0);
    idle(DLY);
    check("R7 not yet active", 32'(sof_active), 32'h0);
    idle(1);
    check("R7 active", 32'(sof_active), 32'h1);
    check("R7 first pulse", 32'(sof_first), 32'h1);
    check("R11 no bulk before frame", 32'(bulk_run), 32'h0);
    idle(1);
    check("R7 first pulse ends", 32'(sof_first), 32'h0);
    write_reg(32'h0000_00A0);
    idle(DLY + 3);
    check("R7 rewrite keeps active", 32'(sof_active), 32'h1);

    // R11: bulk enable sampled at frame pulse
    @(negedge clk); sof_pulse = 1;
    @(negedge clk); sof_pulse = 0;
    check("R11 bulk on at frame", 32'(bulk_run), 32'h1);
    write_reg(32'h0000_0080);
    idle(3);
    check("R11 bulk held mid-frame", 32'(bulk_run), 32'h1);
    @(negedge clk); sof_pulse = 1;
    @(negedge clk); sof_pulse = 0;
    check("R11 bulk off at next frame", 32'(bulk_run), 32'h0);
    write_reg(32'h0000_00A0);
    @(negedge clk); sof_pulse = 1;
    @(negedge clk); sof_pulse = 0;
    check("R11 bulk on again", 32'(bulk_run), 32'h1);

    // R8: leaving operational cancels
    write_reg(32'h0000_00C0);
    idle(1);
    check("R8 sof off after leave", 32'(sof_active), 32'h0);
    idle(1);
    check("R11 bulk cleared", 32'(bulk_run), 32'h0);
    write_reg(32'h0000_0080);
    idle(DLY / 2);
    write_reg(32'h0000_0040);
    idle(DLY + 5);
    check("R8 cancelled count", 32'(sof_active), 32'h0);

    // R9: wake enable does not affect interrupts
    write_reg(32'h0000_04C0);
    @(negedge clk); resume_status = 1; irq_event = 1;
    @(negedge clk); resume_status = 0; irq_event = 0;
    check("R9 wakeup raised", 32'(wakeup_req), 32'h1);
    check("R9 host_irq unaffected", 32'(host_irq), 32'h1);
    check("R9 smi_irq unaffected", 32'(smi_irq), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule